// File: doc/BRIEF.md
# Port Interrupt Status Classifier

This block sits between a storage port's interrupt status register and the sequencing logic that services the port. On a valid strobe it takes one snapshot of the 32-bit status word and masks it with the interrupt-enable word. It then reduces the result to one prioritised event: port reset request, fatal-error recovery, transfer complete, or link connect. The event is registered and held until the controlling logic acknowledges it.

In the cycle after the snapshot, the block also issues write-1-to-clear strobes. One goes back to the status register. When a link change needs it, another goes to the companion serial-link error register. When fatal recovery is chosen, it pulses the signals that stop the command engine and clear the enable word.

Two status flags live in the block. A sticky connect flag is consumed by a reset sequencer. A command-outstanding flag is set on command issue and dropped when a transfer completes.

Top module: `port_irq_classifier`

## Requirements
- R1: If the masked status word (status AND enable) is zero when sampled, the next cycle shows no event and no clear strobe of either register.
- R2: Only bits that are set in both the status word and the enable word take part in classification. Bit positions: 0 register-FIS received, 1 PIO-setup received, 6 port connect change, 22 PHY-ready change, 26 interface non-fatal error, 27 interface fatal error, 28 host bus data error, 29 host bus fatal error, 30 task-file error.
- R3: Masked bit 26 yields the reset event (`evt_onehot` = 4'b0010), whatever other bits are set.
- R4: If bit 26 is clear and any of bits 27 to 30 is set, the fatal event is chosen (4'b0100). In the same cycle `recover_stb` and `ie_clr_stb` pulse for one cycle, and any completion is suppressed.
- R5: If bit 0 or bit 1 is set and none of bits 26 to 30 is set, the completion event is chosen (4'b1000) and `wait_busy` is cleared.
- R6: If bits 22 and 6 are both set, `serr_clr_stb` pulses for one cycle with `serr_clr_val` equal to the error word sampled with the status word, and `connect_seen` is set. This happens alongside any other event. The link event (4'b0001) is shown only when no other event applies.
- R7: A non-zero masked word gives a one-cycle `st_clr_stb`, with `st_clr_mask` equal to the whole raw status word.
- R8: The event appears on the clock edge that samples the strobe and is held, one-hot, until `evt_ack`. It reads zero from the edge that samples the acknowledge.
- R9: A valid strobe that arrives while an event is held is ignored: no strobes, no flag changes, and the held event is unchanged.
- R10: `connect_seen` stays set until `connect_consume`, and a set in the same cycle wins. `cmd_issue` sets `wait_busy`, and it wins over a completion in the same cycle.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Status snapshot strobe |
| st_word | input | 32 | Port interrupt status word |
| ie_word | input | 32 | Interrupt-enable word |
| serr_word | input | 32 | Current serial-link error register value |
| evt_ack | input | 1 | Acknowledge of the held event |
| connect_consume | input | 1 | Reset sequencer consumes the connect flag |
| cmd_issue | input | 1 | A command was issued; sets `wait_busy` |
| evt_onehot | output | 4 | Held event: bit0 link, bit1 reset, bit2 fatal, bit3 done |
| evt_pend | output | 1 | An event is held awaiting acknowledge |
| st_clr_stb | output | 1 | Write-1-to-clear strobe to the status register |
| st_clr_mask | output | 32 | Value written back to the status register |
| serr_clr_stb | output | 1 | Write-1-to-clear strobe to the error register |
| serr_clr_val | output | 32 | Value written back to the error register |
| recover_stb | output | 1 | Stop command-list processing and frame receive |
| ie_clr_stb | output | 1 | Write zero to the interrupt-enable word |
| connect_seen | output | 1 | Sticky connect flag |
| wait_busy | output | 1 | Command outstanding |

## Verification
Random status words are built mostly from the nine meaningful bits, with some stray bits added. They are combined with full, random or empty enable words, so several priority classes often compete in one sample. Directed words then isolate each precedence step: reset over fatal, fatal over completion, and completion over link. Further directed cases cover a link change without its PHY partner, which must clear the status register but raise no event, and a word that the enable mask zeroes completely. A second strobe sent while an event is held shows that the hold really blocks sampling. Acknowledge cycles that also consume the connect flag or issue a command confirm the flag rules.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned EV_W   = 4;

    // status bit positions (fixed by the register the block reads)
    localparam int unsigned B_D2H     = 0;
    localparam int unsigned B_PIO     = 1;
    localparam int unsigned B_PCON    = 6;
    localparam int unsigned B_PHYRDY  = 22;
    localparam int unsigned B_NONFAT  = 26;
    localparam int unsigned B_IFFAT   = 27;
    localparam int unsigned B_HBDATA  = 28;
    localparam int unsigned B_HBFAT   = 29;
    localparam int unsigned B_TFERR   = 30;

    localparam int unsigned N_FATAL = 4;
    localparam int unsigned FATAL_POS [N_FATAL] = '{B_IFFAT, B_HBDATA, B_HBFAT, B_TFERR};

    typedef enum logic [EV_W-1:0] {
        EV_NONE  = 4'b0000,
        EV_LINK  = 4'b0001,
        EV_RESET = 4'b0010,
        EV_FATAL = 4'b0100,
        EV_DONE  = 4'b1000
    } pirq_ev_e;

    typedef struct packed {
        pirq_ev_e ev;
        logic     link_combo;
        logic     any;
    } pirq_cls_t;

    function automatic logic [WORD_W-1:0] bit_at(input int unsigned pos);
        logic [WORD_W-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
    import pirq_pkg::*;
(
    input  logic [WORD_W-1:0] st_word,
    input  logic [WORD_W-1:0] ie_word,
    output pirq_cls_t         cls
);
    logic [WORD_W-1:0] eff;
    logic [N_FATAL-1:0] fat_hits;
    logic rst_req, fat_req, done_req;

    assign eff = st_word & ie_word;

    for (genvar g = 0; g < N_FATAL; g++) begin : g_fat
        assign fat_hits[g] = eff[FATAL_POS[g]];
    end

    assign rst_req  = eff[B_NONFAT];
    assign fat_req  = |fat_hits;
    assign done_req = eff[B_D2H] | eff[B_PIO];

    always_comb begin
        cls.any        = |eff;
        cls.link_combo = eff[B_PHYRDY] & eff[B_PCON];
        if (rst_req)              cls.ev = EV_RESET;
        else if (fat_req)         cls.ev = EV_FATAL;
        else if (done_req)        cls.ev = EV_DONE;
        else if (cls.link_combo)  cls.ev = EV_LINK;
        else                      cls.ev = EV_NONE;
    end
endmodule

// File: rtl/pirq_evt_hold.sv
module pirq_evt_hold
    import pirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  pirq_ev_e ev_in,
    input  logic     ack,
    output pirq_ev_e ev_out,
    output logic     pend
);
    pirq_ev_e ev_q;

    always_ff @(posedge clk) begin
        if (rst)                          ev_q <= EV_NONE;
        else if (load && ev_in != EV_NONE) ev_q <= ev_in;
        else if (ack)                     ev_q <= EV_NONE;
    end

    assign ev_out = ev_q;
    assign pend   = (ev_q != EV_NONE);
endmodule

// File: rtl/pirq_flags.sv
module pirq_flags (
    input  logic clk,
    input  logic rst,
    input  logic link_set,
    input  logic consume,
    input  logic issue,
    input  logic done,
    output logic link_seen,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            link_seen <= 1'b0;
            busy      <= 1'b0;
        end else begin
            if (link_set)      link_seen <= 1'b1;
            else if (consume)  link_seen <= 1'b0;
            if (issue)         busy <= 1'b1;
            else if (done)     busy <= 1'b0;
        end
    end
endmodule

// File: rtl/port_irq_classifier.sv
module port_irq_classifier
    import pirq_pkg::*;
#(
    parameter int unsigned W = pirq_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         st_valid,
    input  logic [W-1:0] st_word,
    input  logic [W-1:0] ie_word,
    input  logic [W-1:0] serr_word,
    input  logic         evt_ack,
    input  logic         connect_consume,
    input  logic         cmd_issue,
    output logic [3:0]   evt_onehot,
    output logic         evt_pend,
    output logic         st_clr_stb,
    output logic [W-1:0] st_clr_mask,
    output logic         serr_clr_stb,
    output logic [W-1:0] serr_clr_val,
    output logic         recover_stb,
    output logic         ie_clr_stb,
    output logic         connect_seen,
    output logic         wait_busy
);
    pirq_cls_t cls;
    pirq_ev_e  ev_held;
    logic      take;

    pirq_decode u_dec (
        .st_word (st_word),
        .ie_word (ie_word),
        .cls     (cls)
    );

    assign take = st_valid & ~evt_pend;

    pirq_evt_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .ev_in  (cls.ev),
        .ack    (evt_ack),
        .ev_out (ev_held),
        .pend   (evt_pend)
    );

    pirq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .link_set  (take & cls.link_combo),
        .consume   (connect_consume),
        .issue     (cmd_issue),
        .done      (take & (cls.ev == EV_DONE)),
        .link_seen (connect_seen),
        .busy      (wait_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_clr_stb   <= 1'b0;
            st_clr_mask  <= '0;
            serr_clr_stb <= 1'b0;
            serr_clr_val <= '0;
            recover_stb  <= 1'b0;
            ie_clr_stb   <= 1'b0;
        end else begin
            st_clr_stb   <= take & cls.any;
            st_clr_mask  <= (take & cls.any) ? st_word : '0;
            serr_clr_stb <= take & cls.link_combo;
            serr_clr_val <= (take & cls.link_combo) ? serr_word : '0;
            recover_stb  <= take & (cls.ev == EV_FATAL);
            ie_clr_stb   <= take & (cls.ev == EV_FATAL);
        end
    end

    assign evt_onehot = ev_held;
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         st_valid,
    input logic [W-1:0] st_word,
    input logic [W-1:0] ie_word,
    input logic         evt_ack,
    input logic         connect_consume,
    input logic         cmd_issue,
    input logic [3:0]   evt_onehot,
    input logic         evt_pend,
    input logic         st_clr_stb,
    input logic         serr_clr_stb,
    input logic         recover_stb,
    input logic         ie_clr_stb,
    input logic         connect_seen,
    input logic         wait_busy
);
    logic [W-1:0] eff;
    assign eff = st_word & ie_word;

    assert_zero_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        st_valid && !evt_pend && (eff == '0) |=> !st_clr_stb && !serr_clr_stb && (evt_onehot == 4'b0));

    assert_reset_first_R3: assert property (@(posedge clk) disable iff (rst)
        st_valid && !evt_pend && eff[26] |=> (evt_onehot == 4'b0010));

    assert_recover_pair_R4: assert property (@(posedge clk) disable iff (rst)
        recover_stb |-> ie_clr_stb && (evt_onehot == 4'b0100));

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
        st_valid && !evt_pend && (eff[0] || eff[1]) && (eff[30:26] == 5'b0) && !cmd_issue
        |=> (evt_onehot == 4'b1000) && !wait_busy);

    assert_serr_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        serr_clr_stb |=> !serr_clr_stb);

    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_onehot));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        evt_pend && !evt_ack |=> $stable(evt_onehot));

    assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        st_valid && evt_pend |=> !st_clr_stb && !serr_clr_stb && !recover_stb);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        connect_seen && !connect_consume |=> connect_seen);
endmodule

bind port_irq_classifier pirq_chk #(.W(W)) chk_i (.*);

// File: tb/port_irq_classifier_tb.sv
module port_irq_classifier_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic [31:0] st_word = '0, ie_word = '0, serr_word = '0;
    logic        evt_ack = 1'b0, connect_consume = 1'b0, cmd_issue = 1'b0;
    logic [3:0]  evt_onehot;
    logic        evt_pend, st_clr_stb, serr_clr_stb, recover_stb, ie_clr_stb;
    logic        connect_seen, wait_busy;
    logic [31:0] st_clr_mask, serr_clr_val;

    int n_chk = 0, n_fail = 0;
    logic m_conn = 1'b0, m_wait = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_irq_classifier dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_ev(input logic [31:0] e);
        if (e[26])                return 4'b0010;
        else if (|e[30:27])       return 4'b0100;
        else if (e[0] | e[1])     return 4'b1000;
        else if (e[22] & e[6])    return 4'b0001;
        else                      return 4'b0000;
    endfunction

    // sample, check strobes, then acknowledge
    task automatic run_word(input logic [31:0] st, input logic [31:0] ie, input logic [31:0] se,
                            input logic cons, input logic iss);
        logic [31:0] e;
        logic [3:0]  ev;
        logic        combo;
        e = st & ie;
        ev = exp_ev(e);
        combo = e[22] & e[6];
        st_word = st; ie_word = ie; serr_word = se; st_valid = 1'b1;
        @(negedge clk);
        st_valid = 1'b0;
        if (combo) m_conn = 1'b1;
        if (ev == 4'b1000) m_wait = 1'b0;
        chk("R8 event", {28'b0, evt_onehot}, {28'b0, ev});
        chk("R2/R3/R4/R5 pending", {31'b0, evt_pend}, {31'b0, ev != 0});
        chk("R7 st clear stb", {31'b0, st_clr_stb}, {31'b0, e != 0});
        chk("R7 st clear mask", st_clr_mask, (e != 0) ? st : 32'b0);
        chk("R6 serr stb", {31'b0, serr_clr_stb}, {31'b0, combo});
        if (combo) chk("R6 serr val", serr_clr_val, se);
        chk("R4 recover", {30'b0, recover_stb, ie_clr_stb}, {30'b0, ev == 4'b0100, ev == 4'b0100});
        chk("R6 connect_seen", {31'b0, connect_seen}, {31'b0, m_conn});
        chk("R5 wait_busy", {31'b0, wait_busy}, {31'b0, m_wait});
        if (e == 0) chk("R1 quiet", {27'b0, st_clr_stb, evt_onehot}, 32'b0);
        evt_ack = 1'b1; connect_consume = cons; cmd_issue = iss;
        @(negedge clk);
        evt_ack = 1'b0; connect_consume = 1'b0; cmd_issue = 1'b0;
        if (cons) m_conn = 1'b0;
        if (iss)  m_wait = 1'b1;
        chk("R8 ack clears", {27'b0, evt_pend, evt_onehot}, 32'b0);
        chk("R7 stb one cycle", {30'b0, st_clr_stb, serr_clr_stb}, 32'b0);
        chk("R10 flags", {30'b0, connect_seen, wait_busy}, {30'b0, m_conn, m_wait});
    endtask

    function automatic logic [31:0] rnd_word();
        logic [31:0] w;
        int unsigned pos [9] = '{0, 1, 6, 22, 26, 27, 28, 29, 30};
        w = $urandom & $urandom & $urandom;
        foreach (pos[i]) if ($urandom_range(3) == 0) w[pos[i]] = 1'b1;
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 reset outputs", {21'b0, evt_onehot, evt_pend, st_clr_stb, serr_clr_stb,
            recover_stb, ie_clr_stb, connect_seen, wait_busy}, 32'b0);
        chk("R11 reset masks", st_clr_mask | serr_clr_val, 32'b0);

        // R1: zero word
        run_word(32'h0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
        // R2: enable mask removes everything
        run_word(32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0);
        // R2: fatal masked off, done survives
        run_word(32'h4000_0001, 32'h0000_0001, 32'h0, 1'b0, 1'b0);
        // R3: reset beats fatal and done, with combo alongside (R6)
        run_word(32'h7C40_0043, 32'hFFFF_FFFF, 32'hDEAD_0005, 1'b0, 1'b1);
        // R4: fatal beats done, wait not cleared
        run_word(32'h1000_0002, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0);
        // R5: done beats link combo
        run_word(32'h0040_0041, 32'hFFFF_FFFF, 32'h0000_1234, 1'b0, 1'b0);
        // R6: link event alone
        run_word(32'h0040_0040, 32'hFFFF_FFFF, 32'hFFFF_0000, 1'b1, 1'b1);
        // R6: port connect without PHY change clears status only
        run_word(32'h0000_0040, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0);

        // R9: valid while pending is ignored
        st_word = 32'h0400_0000; ie_word = 32'hFFFF_FFFF; st_valid = 1'b1;
        @(negedge clk);
        st_word = 32'h0040_0041; serr_word = 32'h55;
        @(negedge clk);
        st_valid = 1'b0;
        chk("R9 held event", {28'b0, evt_onehot}, 32'h2);
        chk("R9 no strobes", {29'b0, st_clr_stb, serr_clr_stb, recover_stb}, 32'b0);
        chk("R9 no flag change", {30'b0, connect_seen, wait_busy}, {30'b0, m_conn, m_wait});
        evt_ack = 1'b1;
        @(negedge clk);
        evt_ack = 1'b0;
        chk("R8 ack after hold", {28'b0, evt_onehot}, 32'b0);

        // R10: set wins over consume in the same cycle
        m_conn = 1'b1;
        st_word = 32'h0040_0040; st_valid = 1'b1; connect_consume = 1'b1;
        @(negedge clk);
        st_valid = 1'b0; connect_consume = 1'b0;
        chk("R10 set wins", {31'b0, connect_seen}, 32'b1);
        evt_ack = 1'b1;
        @(negedge clk);
        evt_ack = 1'b0;

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ie;
            case ($urandom_range(3))
                0:       ie = $urandom;
                1:       ie = 32'h0;
                default: ie = 32'hFFFF_FFFF;
            endcase
            run_word(rnd_word(), ie, $urandom, $urandom_range(1) == 1, $urandom_range(2) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule